// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a 16-bit memory port and a decoder that consumes instruction bytes one at a time. While the decoder works, the block keeps fetching ahead. Whenever it has enough free space it raises a fetch request carrying a 20-bit byte address. The memory side returns either a full 16-bit word or a single byte, marked by two lane-valid bits. The queue holds at most six bytes and hands them to the consumer strictly in the order of their addresses.

A change of control flow is signalled with a redirect pulse and a new address. The redirect empties the queue in one cycle and reloads the fetch pointer. A fetch that is still outstanding at that moment is discarded when its data comes back. After an odd target address the block fetches one byte first, so that every later fetch is word-aligned.

Top module: `prefetch_byte_queue`

## Requirements
- R1: `fill_level` reports the number of bytes held, and it never exceeds DEPTH (6 by default).
- R2: At most one fetch is outstanding. `fetch_req` is never raised while a fetch waits for its data, and `fetch_addr` always equals the internal fetch pointer.
- R3: A word fetch (`fetch_word`=1) is requested only at an even pointer with at least two free slots. At an even pointer with one free slot, no request is made.
- R4: At an odd pointer, the block requests a single byte (`fetch_word`=0) whenever at least one slot is free.
- R5: In returned data, bits [7:0] (lane 0) carry the byte at the even address and bits [15:8] (lane 1) carry the byte at the odd address. `ret_lanes[i]` marks lane i as valid. Valid lanes are queued lane 0 first, and the fetch pointer advances by the number of valid lanes.
- R6: A `take` on a non-empty queue produces `take_valid`=1 on the next cycle, with `take_byte` set to the oldest byte. Bytes leave in address order.
- R7: A `take` on an empty queue is ignored. `take_valid` stays 0 on the next cycle and the fill level is unchanged.
- R8: A `redirect` empties the queue by the next cycle and loads `redirect_addr` into the fetch pointer. It suppresses `fetch_req` in its own cycle, ignores a `take` in the same cycle, and causes data of any fetch outstanding at that moment to be dropped.
- R9: After reset the queue is empty, the pointer equals RESET_ADDR (0), no fetch is outstanding and `take_valid` is 0.
- R10: Returned data while no fetch is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | output | 1 | Fetch request |
| fetch_word | output | 1 | 1 = two-byte fetch, 0 = one byte |
| fetch_addr | output | 20 | Byte address of the fetch |
| fetch_gnt | input | 1 | Request accepted this cycle |
| ret_valid | input | 1 | Returned data present |
| ret_data | input | 16 | Returned bytes, lane 0 in [7:0] |
| ret_lanes | input | 2 | Valid flag per lane |
| take | input | 1 | Consumer pops one byte |
| take_valid | output | 1 | Popped byte present (registered) |
| take_byte | output | 8 | Popped byte (registered) |
| fill_level | output | 3 | Bytes held |
| redirect | input | 1 | Flush and reload the fetch pointer |
| redirect_addr | input | 20 | New fetch address |

## Verification
`fill_level`, `take_valid` and `take_byte` are registered, so the effect of `take`, returned data or `redirect` shows up one clock edge later. `fetch_req`, `fetch_word` and `fetch_addr` follow the registered pointer and the current `redirect` within the same cycle. The bench drives inputs after the falling edge. It compares the request outputs against its own model one nanosecond later in that same half-cycle, and compares the registered outputs against the values its model predicted for the previous edge. A reference stream of bytes computed from the address lets every popped byte be checked across word and byte-only memory modes, random grants, latencies and redirects.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lanes_t;

  function automatic logic [1:0] lane_count(input lanes_t l);
    return {1'b0, l[0]} + {1'b0, l[1]};
  endfunction
endpackage

// File: rtl/pfq_store.sv
module pfq_store
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  word_t            wr_data,
  input  logic             rd_req,
  output byte_t            rd_byte,
  output logic             rd_valid,
  output logic [CNT_W-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  byte_t            slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_n1;
  logic [1:0]       n_wr;
  byte_t            first_byte;
  logic             do_rd;

  assign n_wr       = lane_count({wr_hi, wr_lo});
  assign first_byte = wr_lo ? wr_data[BYTE_W-1:0] : wr_data[WORD_W-1:BYTE_W];
  assign wr_ptr_n1  = step(wr_ptr);
  assign do_rd      = rd_req && (level != '0) && !clr;

  // Storage slots: the first accepted lane goes to wr_ptr, the second to wr_ptr+1
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (n_wr != 2'd0 && wr_ptr == PTR_W'(g))
        slot_q[g] <= first_byte;
      else if (n_wr == 2'd2 && wr_ptr_n1 == PTR_W'(g))
        slot_q[g] <= wr_data[WORD_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else if (clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      rd_valid <= 1'b0;
    end else begin
      case (n_wr)
        2'd1:    wr_ptr <= wr_ptr_n1;
        2'd2:    wr_ptr <= step(wr_ptr_n1);
        default: wr_ptr <= wr_ptr;
      endcase
      if (do_rd) begin
        rd_ptr  <= step(rd_ptr);
        rd_byte <= slot_q[rd_ptr];
      end
      rd_valid <= do_rd;
      level    <= level + CNT_W'(n_wr) - CNT_W'(do_rd);
    end
  end
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter int          DEPTH      = 6,
  parameter int          ADDR_W     = 20,
  parameter int          CNT_W      = $clog2(DEPTH + 1),
  parameter logic [19:0] RESET_ADDR = 20'h00000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic [CNT_W-1:0]  level,
  output logic              req,
  output logic              req_word,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              gnt,
  input  logic              rsp_valid,
  input  lanes_t            rsp_lanes,
  output logic              acc_lo,
  output logic              acc_hi
);
  logic [ADDR_W-1:0] ptr_q;
  logic              busy_q;   // one fetch outstanding
  logic              stale_q;  // outstanding fetch must be discarded
  logic [CNT_W-1:0]  free;
  logic              room;
  logic              rsp_ok;

  assign free     = CNT_W'(DEPTH) - level;
  assign room     = ptr_q[0] ? (free >= CNT_W'(1)) : (free >= CNT_W'(2));
  assign req      = !busy_q && !flush && room;
  assign req_word = !ptr_q[0];
  assign req_addr = ptr_q;

  assign rsp_ok = rsp_valid && busy_q && !stale_q && !flush;
  assign acc_lo = rsp_ok && rsp_lanes[0];
  assign acc_hi = rsp_ok && rsp_lanes[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= ADDR_W'(RESET_ADDR);
      busy_q  <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      if (flush)
        ptr_q <= flush_addr;
      else if (rsp_ok)
        ptr_q <= ptr_q + ADDR_W'(lane_count({acc_hi, acc_lo}));

      if (rsp_valid && busy_q) begin
        busy_q  <= 1'b0;
        stale_q <= 1'b0;
      end else begin
        if (req && gnt)
          busy_q <= 1'b1;
        if (flush && busy_q)
          stale_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prefetch_byte_queue.sv
module prefetch_byte_queue
  import pfq_pkg::*;
#(
  parameter int          DEPTH      = 6,
  parameter int          ADDR_W     = 20,
  parameter logic [19:0] RESET_ADDR = 20'h00000,
  localparam int         CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              fetch_req,
  output logic              fetch_word,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_gnt,
  input  logic              ret_valid,
  input  logic [15:0]       ret_data,
  input  logic [1:0]        ret_lanes,
  input  logic              take,
  output logic              take_valid,
  output logic [7:0]        take_byte,
  output logic [CNT_W-1:0]  fill_level,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr
);
  logic acc_lo, acc_hi;

  pfq_fetch #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_ADDR(RESET_ADDR)
  ) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .flush      (redirect),
    .flush_addr (redirect_addr),
    .level      (fill_level),
    .req        (fetch_req),
    .req_word   (fetch_word),
    .req_addr   (fetch_addr),
    .gnt        (fetch_gnt),
    .rsp_valid  (ret_valid),
    .rsp_lanes  (ret_lanes),
    .acc_lo     (acc_lo),
    .acc_hi     (acc_hi)
  );

  pfq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .clr      (redirect),
    .wr_lo    (acc_lo),
    .wr_hi    (acc_hi),
    .wr_data  (ret_data),
    .rd_req   (take),
    .rd_byte  (take_byte),
    .rd_valid (take_valid),
    .level    (fill_level)
  );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 20,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_req,
  input logic              fetch_word,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_gnt,
  input logic              take,
  input logic              take_valid,
  input logic [CNT_W-1:0]  fill_level,
  input logic              redirect
);
  a_r1_level_bounded: assert property (@(posedge clk) disable iff (rst)
    fill_level <= CNT_W'(DEPTH));

  a_r2_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    fetch_req && fetch_gnt |=> !fetch_req);

  a_r3_word_needs_room: assert property (@(posedge clk) disable iff (rst)
    fetch_req && fetch_word |-> (fill_level <= CNT_W'(DEPTH - 2)) && !fetch_addr[0]);

  a_r4_odd_is_byte: assert property (@(posedge clk) disable iff (rst)
    fetch_req && fetch_addr[0] |-> !fetch_word);

  a_r6_take_served: assert property (@(posedge clk) disable iff (rst)
    take && (fill_level != '0) && !redirect |=> take_valid);

  a_r7_empty_take: assert property (@(posedge clk) disable iff (rst)
    take && (fill_level == '0) |=> !take_valid && (fill_level <= CNT_W'(2)));

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (fill_level == '0) && !take_valid);

  a_r8_no_req_on_flush: assert property (@(posedge clk) disable iff (rst)
    redirect |-> !fetch_req);
endmodule

bind prefetch_byte_queue pfq_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_pfq_chk (
  .clk        (clk),
  .rst        (rst),
  .fetch_req  (fetch_req),
  .fetch_word (fetch_word),
  .fetch_addr (fetch_addr),
  .fetch_gnt  (fetch_gnt),
  .take       (take),
  .take_valid (take_valid),
  .fill_level (fill_level),
  .redirect   (redirect)
);

// File: tb/prefetch_byte_queue_test.sv
`timescale 1ns/1ps
module prefetch_byte_queue_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req, fetch_word;
  logic [19:0] fetch_addr;
  logic        fetch_gnt = 1'b0;
  logic        ret_valid = 1'b0;
  logic [15:0] ret_data  = '0;
  logic [1:0]  ret_lanes = '0;
  logic        take = 1'b0;
  logic        take_valid;
  logic [7:0]  take_byte;
  logic [2:0]  fill_level;
  logic        redirect = 1'b0;
  logic [19:0] redirect_addr = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prefetch_byte_queue uut (
    .clk(clk), .rst(rst),
    .fetch_req(fetch_req), .fetch_word(fetch_word), .fetch_addr(fetch_addr),
    .fetch_gnt(fetch_gnt),
    .ret_valid(ret_valid), .ret_data(ret_data), .ret_lanes(ret_lanes),
    .take(take), .take_valid(take_valid), .take_byte(take_byte),
    .fill_level(fill_level),
    .redirect(redirect), .redirect_addr(redirect_addr)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] + a[15:8] * 8'd3 + {4'd0, a[19:16]} * 8'd5;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // model state
  int          cnt_m = 0;
  logic [19:0] ptr_m = '0;
  logic [19:0] cons_m = '0;
  bit          pend = 0, pend_stale = 0, pend_word = 0;
  logic [19:0] pend_addr = '0;
  int          pend_cnt = 0;
  bit          exp_pv = 0;
  logic [7:0]  exp_pb = '0;
  string       lvl_tag = "R1";
  string       pv_tag  = "R6";
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 level", int'(fill_level), 0);
    chk("R9 take_valid", int'(take_valid), 0);
    rst = 1'b0;
    #1;
    chk("R9 req", int'(fetch_req), 1);
    chk("R9 addr", int'(fetch_addr), 0);
    chk("R9 word", int'(fetch_word), 1);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit fl, pp, gn, real_rsp, narrow, exp_req, acc, popped, gfire;
      int n, phase;
      logic [19:0] fa;
      @(negedge clk);
      lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      phase = cyc / 400;
      narrow = ((cyc / 800) % 2) == 1;

      // registered outputs from the previous edge
      chk(lvl_tag, int'(fill_level), cnt_m);
      chk("R1 bound", int'(fill_level <= 3'd6), 1);
      chk(pv_tag, int'(take_valid), int'(exp_pv));
      if (exp_pv) chk("R6 byte order", int'(take_byte), int'(exp_pb));

      // stimulus
      fa = {lfsr[11:0], lfsr[15:8]};
      if (cyc == 300) begin fl = 1; fa = 20'hFFFFD; end
      else if (cyc == 1300) begin fl = 1; fa = 20'h12345; end
      else fl = (lfsr[15:10] == 6'd0);
      if (cyc < 150) pp = 0;
      else if (phase % 2 == 0) pp = lfsr[2] | lfsr[3];
      else pp = lfsr[2] & lfsr[3];
      gn = lfsr[4] | lfsr[5];
      real_rsp = pend && (pend_cnt == 0);
      redirect = fl; redirect_addr = fa; take = pp; fetch_gnt = gn;
      if (real_rsp) begin
        ret_valid = 1'b1;
        ret_data  = {mem_byte({pend_addr[19:1], 1'b1}), mem_byte({pend_addr[19:1], 1'b0})};
        ret_lanes = pend_word ? (narrow ? 2'b01 : 2'b11) : 2'b10;
      end else if (!pend && lfsr[6] && lfsr[7] && lfsr[8]) begin
        ret_valid = 1'b1; ret_data = 16'hA5C3; ret_lanes = 2'b11;  // stray data
      end else begin
        ret_valid = 1'b0; ret_lanes = 2'b00;
      end
      #1;

      // request outputs in this cycle
      exp_req = !fl && !pend && (ptr_m[0] ? (cnt_m <= 5) : (cnt_m <= 4));
      if (fl) chk("R8 no request", int'(fetch_req), 0);
      else if (!ptr_m[0] && cnt_m == 5) chk("R3 one free slot", int'(fetch_req), 0);
      else if (ptr_m[0]) chk("R4 odd request", int'(fetch_req), int'(exp_req));
      else chk("R2 request", int'(fetch_req), int'(exp_req));
      if (exp_req) begin
        chk("R2 addr", int'(fetch_addr), int'(ptr_m));
        chk(ptr_m[0] ? "R4 byte size" : "R3 word size", int'(fetch_word), int'(!ptr_m[0]));
      end
      gfire = exp_req && gn;

      // model update for the coming edge
      acc = real_rsp && !pend_stale && !fl;
      n = acc ? (int'(ret_lanes[0]) + int'(ret_lanes[1])) : 0;
      popped = pp && (cnt_m > 0) && !fl;
      lvl_tag = fl ? "R8 level" : (ret_valid && !real_rsp) ? "R10 level" :
                (real_rsp && !acc) ? "R8 dropped" : (n > 0) ? "R5 level" : "R1 level";
      pv_tag  = fl ? "R8 take" : (pp && cnt_m == 0) ? "R7 empty take" : "R6 take";
      exp_pv = popped;
      if (popped) begin exp_pb = mem_byte(cons_m); cons_m = cons_m + 20'd1; end
      if (fl) begin
        cnt_m = 0; cons_m = fa; ptr_m = fa;
      end else begin
        cnt_m = cnt_m + n - int'(popped);
        ptr_m = ptr_m + 20'(n);
      end
      if (real_rsp) pend = 0;
      else if (pend) begin
        if (fl) pend_stale = 1;
        pend_cnt--;
      end
      if (gfire) begin
        pend = 1; pend_stale = 0; pend_addr = fetch_addr; pend_word = fetch_word;
        pend_cnt = int'(lfsr[0]) + int'(lfsr[1]);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule